// File: doc/BRIEF.md
# Dual-Edge Transition-Count Serial Transmitter

This block sends a 16-bit word over one wire without a separate clock. It cuts the word into four 4-bit segments and inverts any segment that holds more than two ones, so each segment ends up with at most two ones. It then sends a short packet of symbols. The packet holds the one-counts of each pair of segments, a compact index code for every segment that is not empty, and the inversion flags. Each symbol carries a number n, which goes out as n changes of the line level, one per clock, on rising and falling edges alike. An idle gap of fixed length separates one symbol from the next. A receiver only has to count edges between gaps.

A producer offers a word with `in_valid`. The word is taken on any clock edge where the block is idle, and `busy` then stays high until the gap after the last symbol has ended. Inside the block, a slot state machine walks through the states ST_IDLE, ST_CNOI_LO, ST_IDX1, ST_IDX2, ST_CNOI_HI, ST_IDX3, ST_IDX4 and ST_FLAGS. ST_IDLE moves to ST_CNOI_LO when a word is taken. Each symbol-slot state moves on when the edge generator reports that its gap is over. The move goes to the next slot whose symbol exists: an index slot is skipped when its segment holds no ones. ST_FLAGS returns to ST_IDLE.

Top module: `edge_count_tx`

## Requirements
- R1: A word is taken on a clock edge where `in_valid` is high and `busy` is low. `busy` is high in the cycle after that edge.
- R2: A segment (S1 = bits 3:0, S2 = 7:4, S3 = 11:8, S4 = 15:12) with three or four ones is bitwise inverted, and its flag is set. Any other segment is sent unchanged with flag 0.
- R3: Header symbol values are computed from the per-segment one-counts after encoding (0..2, 2 bits each). The first symbol is {count(S2), count(S1)} + 1. The symbol after the first segment pair is {count(S4), count(S3)} + 1.
- R4: An encoded segment with one set bit sends index code 1, 2, 3 or 4 for bit 0, 1, 2 or 3.
- R5: An encoded segment with two set bits sends this index code: 0011→1, 0101→2, 0110→3, 1001→4, 1010→5, 1100→6.
- R6: The packet order is: header of S1/S2, index of S1, index of S2, header of S3/S4, index of S3, index of S4, then flags. A segment with no ones sends no index symbol.
- R7: The last symbol is {F4, F3, F2, F1} + 1, where Fk is the flag of segment Sk.
- R8: A symbol of value n is n consecutive clock cycles in which the line toggles once each cycle. The first toggle comes on the edge after the symbol is loaded. The line never returns to a fixed level on its own.
- R9: Every symbol is followed by exactly 4 clock cycles with no toggle.
- R10: `busy` falls on the edge that ends the final gap. A packet lasts the sum of (value + 4) over its symbols, in cycles after the accepting edge.
- R11: A synchronous active-high reset drives the line low and `busy` low, and drops any packet in progress.
- R12: `in_valid` raised while `busy` is high is ignored. The current packet continues unchanged, and no new packet starts after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Word offered |
| in_word | input | 16 | Word to send |
| busy | output | 1 | Packet in progress; words are not taken |
| line_out | output | 1 | Serial line, one toggle per transmitted count |

## Verification
The accepting edge only loads the first symbol. The first toggle is due on the next edge. Each later cycle is either a toggle or a gap cycle, in an order fixed by the expected symbol list. `busy` falls exactly (sum of value + 4) edges after acceptance. The bench drives and samples on the falling clock edge. It builds a per-cycle expected trace of toggles and gaps from its own model of the encoding, and compares the line and `busy` against that trace once per cycle, starting at the accepting edge. A packet length that is wrong by even one cycle therefore appears as a mismatch.

// File: rtl/ecs_pkg.sv
package ecs_pkg;
    localparam int WORD_W = 16;
    localparam int SEG_W  = 4;
    localparam int NSEG   = WORD_W / SEG_W;
    localparam int CODE_W = 3;
    localparam int NOI_W  = 2;
    localparam int SYM_W  = NSEG + 1;

    typedef struct packed {
        logic [NOI_W-1:0]  noi;
        logic [CODE_W-1:0] code;
        logic              flag;
    } seg_info_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_CNOI_LO, ST_IDX1, ST_IDX2,
        ST_CNOI_HI, ST_IDX3, ST_IDX4, ST_FLAGS
    } slot_t;
endpackage

// File: rtl/seg_index_map.sv
module seg_index_map import ecs_pkg::*; (
    input  logic [SEG_W-1:0]  pattern,
    output logic [CODE_W-1:0] code
);
    always_comb begin
        unique case (pattern)
            4'b0001, 4'b0011: code = 3'd1;
            4'b0010, 4'b0101: code = 3'd2;
            4'b0100, 4'b0110: code = 3'd3;
            4'b1000, 4'b1001: code = 3'd4;
            4'b1010:          code = 3'd5;
            4'b1100:          code = 3'd6;
            default:          code = 3'd0;
        endcase
    end
endmodule

// File: rtl/seg_encoder.sv
module seg_encoder import ecs_pkg::*; (
    input  logic [SEG_W-1:0] seg_in,
    output seg_info_t        info
);
    localparam int CNT_W = $clog2(SEG_W + 1);

    logic [CNT_W-1:0] ones_in;
    logic [NOI_W-1:0] ones_out;
    logic [SEG_W-1:0] seg_enc;
    logic             invert;

    always_comb begin
        ones_in = '0;
        for (int i = 0; i < SEG_W; i++) ones_in = ones_in + CNT_W'(seg_in[i]);
    end

    assign invert  = (ones_in > CNT_W'(SEG_W / 2));
    assign seg_enc = invert ? ~seg_in : seg_in;

    always_comb begin
        ones_out = '0;
        for (int i = 0; i < SEG_W; i++) ones_out = ones_out + NOI_W'(seg_enc[i]);
    end

    seg_index_map u_map (.pattern(seg_enc), .code(info.code));

    assign info.noi  = ones_out;
    assign info.flag = invert;

    // R2: the encoded segment never carries more than half its width in ones
    always_comb begin
        if (!$isunknown(seg_in)) begin
            p_weight_r2: assert ($countones(seg_enc) <= SEG_W / 2);
        end
    end
endmodule

// File: rtl/edge_gen.sv
module edge_gen #(
    parameter int SYM_BITS = 5,
    parameter int GAP_CYC  = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [SYM_BITS-1:0] load_val,
    output logic                sym_done,
    output logic                line
);
    localparam int GAP_W = $clog2(GAP_CYC + 1);

    typedef enum logic [1:0] {EG_IDLE, EG_EMIT, EG_GAP} eg_phase_t;

    eg_phase_t           phase;
    logic [SYM_BITS-1:0] remain;
    logic [GAP_W-1:0]    gap_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= EG_IDLE;
            remain   <= '0;
            gap_left <= '0;
            line     <= 1'b0;
        end else if (load) begin
            phase  <= EG_EMIT;
            remain <= load_val;
        end else begin
            unique case (phase)
                EG_EMIT: begin
                    line <= ~line;
                    if (remain == SYM_BITS'(1)) begin
                        phase    <= EG_GAP;
                        gap_left <= GAP_W'(GAP_CYC);
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                EG_GAP: begin
                    if (gap_left == GAP_W'(1)) phase <= EG_IDLE;
                    else gap_left <= gap_left - 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign sym_done = (phase == EG_GAP) && (gap_left == GAP_W'(1));

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (phase != EG_EMIT) && !load |=> $stable(line));
    p_step_r8: assert property (@(posedge clk) disable iff (rst)
        (phase == EG_EMIT) && !load |=> (line != $past(line)));
    p_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));
endmodule

// File: rtl/edge_count_tx.sv
module edge_count_tx import ecs_pkg::*; #(
    parameter int GAP_CYC = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              busy,
    output logic              line_out
);
    seg_info_t [NSEG-1:0] enc_now;
    seg_info_t [NSEG-1:0] info_q;
    seg_info_t [NSEG-1:0] info_sel;
    slot_t                state, state_nx;
    logic                 sym_done, load;
    logic [SYM_W-1:0]     load_val;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        seg_encoder u_enc (.seg_in(in_word[g*SEG_W +: SEG_W]), .info(enc_now[g]));
    end

    function automatic slot_t follow(slot_t cur, seg_info_t [NSEG-1:0] inf);
        slot_t nx;
        unique case (cur)
            ST_CNOI_LO: nx = (inf[0].noi != '0) ? ST_IDX1 :
                             (inf[1].noi != '0) ? ST_IDX2 : ST_CNOI_HI;
            ST_IDX1:    nx = (inf[1].noi != '0) ? ST_IDX2 : ST_CNOI_HI;
            ST_IDX2:    nx = ST_CNOI_HI;
            ST_CNOI_HI: nx = (inf[2].noi != '0) ? ST_IDX3 :
                             (inf[3].noi != '0) ? ST_IDX4 : ST_FLAGS;
            ST_IDX3:    nx = (inf[3].noi != '0) ? ST_IDX4 : ST_FLAGS;
            ST_IDX4:    nx = ST_FLAGS;
            default:    nx = ST_IDLE;
        endcase
        return nx;
    endfunction

    function automatic logic [SYM_W-1:0] sym_of(slot_t s, seg_info_t [NSEG-1:0] inf);
        logic [NSEG-1:0]  flags;
        logic [SYM_W-1:0] v;
        for (int k = 0; k < NSEG; k++) flags[k] = inf[k].flag;
        unique case (s)
            ST_CNOI_LO: v = {1'b0, inf[1].noi, inf[0].noi} + SYM_W'(1);
            ST_CNOI_HI: v = {1'b0, inf[3].noi, inf[2].noi} + SYM_W'(1);
            ST_IDX1:    v = SYM_W'(inf[0].code);
            ST_IDX2:    v = SYM_W'(inf[1].code);
            ST_IDX3:    v = SYM_W'(inf[2].code);
            ST_IDX4:    v = SYM_W'(inf[3].code);
            ST_FLAGS:   v = {1'b0, flags} + SYM_W'(1);
            default:    v = '0;
        endcase
        return v;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) info_q <= '0;
        else if (state == ST_IDLE && in_valid) info_q <= enc_now;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (in_valid) state_nx = ST_CNOI_LO;
            default: if (sym_done) state_nx = follow(state, info_q);
        endcase
    end

    assign info_sel = (state == ST_IDLE) ? enc_now : info_q;
    assign load     = (state_nx != state) && (state_nx != ST_IDLE);
    assign load_val = sym_of(state_nx, info_sel);

    // outputs
    always_comb begin
        busy = (state != ST_IDLE);
    end

    edge_gen #(.SYM_BITS(SYM_W), .GAP_CYC(GAP_CYC)) u_edge (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .sym_done(sym_done), .line(line_out)
    );

    p_accept_busy_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && !busy |=> busy);
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(info_q));
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(line_out));
endmodule

// File: tb/sim_edge_count_tx.sv
module sim_edge_count_tx;
    logic        clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        busy, line_out;

    int    n_chk = 0, n_bad = 0;
    logic  exp_line = 1'b0;
    bit    tog [0:255];
    string tog_tag [0:255];
    int    total;

    edge_count_tx u0 (.clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
                      .busy(busy), .line_out(line_out));

    always #10 clk = ~clk;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic add_sym(int v, string tag);
        for (int t = 0; t < v; t++) begin total++; tog[total] = 1; tog_tag[total] = {"R8 ", tag}; end
        for (int t = 0; t < 4; t++) begin total++; tog[total] = 0; tog_tag[total] = "R9"; end
    endtask

    task automatic build(logic [15:0] w);
        int noi [4]; int code [4]; int flags = 0; string itag [4];
        total = 0;
        for (int s = 0; s < 4; s++) begin
            logic [3:0] sg = w[4*s +: 4];
            int c = 0, a = -1, b = -1;
            for (int k = 0; k < 4; k++) c += sg[k];
            itag[s] = "";
            if (c > 2) begin sg = ~sg; flags |= (1 << s); itag[s] = "R2 "; end
            c = 0;
            for (int k = 0; k < 4; k++) if (sg[k]) begin c++; if (a < 0) a = k; else b = k; end
            noi[s] = c;
            if (c == 1) begin code[s] = a + 1; itag[s] = {itag[s], "R4"}; end
            else begin code[s] = b * (b - 1) / 2 + a + 1; itag[s] = {itag[s], "R5"}; end
        end
        add_sym(noi[1] * 4 + noi[0] + 1, "R3");
        if (noi[0] != 0) add_sym(code[0], itag[0]);
        if (noi[1] != 0) add_sym(code[1], itag[1]);
        add_sym(noi[3] * 4 + noi[2] + 1, "R3");
        if (noi[2] != 0) add_sym(code[2], itag[2]);
        if (noi[3] != 0) add_sym(code[3], itag[3]);
        add_sym(flags + 1, (flags != 0) ? "R2 R7" : "R7");
    endtask

    task automatic send_word(logic [15:0] w, bit poke);
        int busy_cnt = 0;
        build(w);
        @(negedge clk); in_word = w; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0; in_word = ~w;
        chk("R1", "busy after accept", busy, 1);
        chk("R8", "line at accept edge", line_out, exp_line);
        busy_cnt += busy;
        for (int i = 1; i <= total; i++) begin
            @(negedge clk);
            if (poke && i == 2) in_valid = 1'b1;
            if (poke && i == 6) in_valid = 1'b0;
            if (tog[i]) exp_line = ~exp_line;
            chk(poke ? {"R12 ", tog_tag[i]} : tog_tag[i], "line", line_out, exp_line);
            chk("R10", "busy during packet", busy, (i < total) ? 1 : 0);
            busy_cnt += busy;
        end
        chk("R6 R10", "packet length", busy_cnt, total);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(poke ? "R12" : "R10", "line after packet", line_out, exp_line);
            chk(poke ? "R12" : "R10", "busy after packet", busy, 0);
        end
    endtask

    task automatic t_idle;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R1", "idle busy", busy, 0);
            chk("R1", "idle line", line_out, exp_line);
        end
    endtask

    task automatic t_reset_mid;
        build(16'hFFFF);
        @(negedge clk); in_word = 16'hFFFF; in_valid = 1'b1;
        @(negedge clk); in_valid = 1'b0;
        repeat (8) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R11", "line in reset", line_out, 0);
        chk("R11", "busy in reset", busy, 0);
        rst = 1'b0; exp_line = 1'b0;
        t_idle();
    endtask

    task automatic finish_up;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R11", "line under reset", line_out, 0);
        chk("R11", "busy under reset", busy, 0);
        rst = 1'b0;
        t_idle();
        send_word(16'h0000, 0);
        send_word(16'h010B, 0);
        send_word(16'h8421, 0);
        send_word(16'h6530, 0);
        send_word(16'hCA90, 0);
        send_word(16'hD7BE, 0);
        send_word(16'h3EC8, 0);
        send_word(16'hFFFF, 1);
        send_word(16'h0F00, 0);
        t_reset_mid();
        send_word(16'h5A6C, 0);
        finish_up();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual running expected finished");
        finish_up();
    end
endmodule